// File: doc/BRIEF.md
# Windowed Framebuffer Address Sequencer

This block sits between a display controller's command path and its frame memory. The memory holds 80 rows of 64 bytes, and each byte packs two 4-bit pixels. The block keeps a column pointer and a row pointer. Each valid pixel byte is written at the cell the pointers select, and the pointers then step inside a rectangular clip window. Each axis has its own window, loaded by a one-cycle pulse that carries a start and an end value.

A mode input sets the walk order. In column-first order the block fills a row of the window from left to right before it moves down. In row-first order it fills a column of the window from top to bottom before it moves right. Every write raises a dirty flag, which the scan-out side clears with a one-cycle acknowledge. The frame memory is built in as an inferred array, and its read port serves scan-out.

Top module: `wfb_addr_seq`

## Requirements
- R1: For each cycle with `px_valid` high, `mem_we` is high, `mem_wdata` equals `px_data`, and `mem_addr` equals row*64 + col, taken from the pointer held before that cycle's clock edge.
- R2: With `walk_vert` = 0, each write moves the column up by one. When the column goes past the column end, it reloads the column start and the row moves up by one. When the row goes past the row end, it reloads the row start.
- R3: With `walk_vert` = 1, each write moves the row up by one. When the row goes past the row end, it reloads the row start and the column moves up by one. When the column goes past the column end, it reloads the column start.
- R4: A column load pulse stores the start and end values modulo 64 and sets the current column to the reduced start. A row load does the same with modulo 80. The new pointer is visible on `mem_addr` in the cycle after the pulse.
- R5: After reset, the pointer is at column 0, row 0, with a column window of 0..63 and a row window of 0..79. With no loads, writes therefore fill addresses 0 to 5119 in order and then wrap to 0.
- R6: A column load and a row load in the same cycle both take effect. A write in that cycle uses the pointer from before the loads. An axis that is loaded in that cycle takes the loaded start instead of its stepped value.
- R7: `dirty` is 0 after reset and goes to 1 in the cycle after any write. It goes to 0 in the cycle after a `dirty_ack` pulse, unless a write happens in the same cycle as the pulse, in which case it stays 1.
- R8: In a cycle with no write and no load, the pointer does not change.
- R9: A byte that has been written can be read back on `rd_data` one cycle after its address is presented on `rd_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| px_valid | input | 1 | Pixel byte valid strobe |
| px_data | input | 8 | Pixel byte (two 4-bit pixels) |
| col_load | input | 1 | One-cycle pulse that loads the column window |
| col_lo_in | input | 8 | Column window start, reduced modulo 64 |
| col_hi_in | input | 8 | Column window end, reduced modulo 64 |
| row_load | input | 1 | One-cycle pulse that loads the row window |
| row_lo_in | input | 8 | Row window start, reduced modulo 80 |
| row_hi_in | input | 8 | Row window end, reduced modulo 80 |
| walk_vert | input | 1 | 0: column-first walk, 1: row-first walk |
| dirty_ack | input | 1 | One-cycle acknowledge from scan-out that clears `dirty` |
| mem_we | output | 1 | Frame memory write enable |
| mem_addr | output | 13 | Frame memory write address |
| mem_wdata | output | 8 | Frame memory write data |
| dirty | output | 1 | Image changed since the last acknowledge |
| rd_addr | input | 13 | Scan-out read address |
| rd_data | output | 8 | Scan-out read data, one cycle of latency |

## Verification
The bench builds the block with its defaults: 64 columns and 80 rows. With these sizes a single unbroken run of 5121 writes covers the reset window across the whole memory, including the step from address 5119 back to 0. Window values of 80 or more exercise the modulo-80 reduction, which no power-of-two row count would test. A window whose start is past its end is also exercised, and in that case the pointer stays on one cell. The tests cover both walk orders, loads that fall in the same cycle as a write, and every ordering of acknowledge and write on the dirty flag.

// File: rtl/wfb_pkg.sv
// Shared types and helpers for the windowed framebuffer address sequencer.
// Assumes: all arithmetic helpers are used with constant divisors.
package wfb_pkg;

    // Walk order: which axis steps on every write.
    typedef enum logic {
        WALK_COL_FIRST = 1'b0,
        WALK_ROW_FIRST = 1'b1
    } walk_e;

    // Reduce a raw window value into the range of one axis.
    function automatic int wrap_mod(input int value, input int span);
        return value % span;
    endfunction

endpackage

// File: rtl/wfb_axis_window.sv
// One axis of the write pointer: holds the window start, the window end and
// the current position. A load pulse takes new bounds (reduced modulo N) and
// moves the position to the start. Without a load, a step takes the next
// position that the walk logic supplies.
// Assumes: nxt is already inside 0..N-1.
module wfb_axis_window
    import wfb_pkg::*;
#(
    parameter  int N  = 64,
    parameter  int IW = 8,
    localparam int W  = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [IW-1:0] lo_in,
    input  logic [IW-1:0] hi_in,
    input  logic          step_en,
    input  logic [W-1:0]  nxt,
    output logic [W-1:0]  cur,
    output logic [W-1:0]  lo,
    output logic [W-1:0]  hi
);

    localparam logic [W-1:0] HI_RESET = W'(N - 1);

    logic [W-1:0] lo_red;
    logic [W-1:0] hi_red;

    // Fold the raw bounds into the axis range.
    always_comb begin
        lo_red = W'(wrap_mod(int'(lo_in), N));
        hi_red = W'(wrap_mod(int'(hi_in), N));
    end

    // Window registers: a load has priority over a step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur <= '0;
            lo  <= '0;
            hi  <= HI_RESET;
        end else if (load) begin
            cur <= lo_red;
            lo  <= lo_red;
            hi  <= hi_red;
        end else if (step_en) begin
            cur <= nxt;
        end
    end

endmodule

// File: rtl/wfb_walk_step.sv
// Next-position logic for the two-axis walk. The primary axis always steps;
// the secondary axis steps only when the primary goes past its end. The
// secondary is then folded back to its start if it has gone past its own end.
// Assumes: positions and bounds are inside their axis ranges.
module wfb_walk_step
    import wfb_pkg::*;
#(
    parameter int CW = 6,
    parameter int RW = 7
) (
    input  walk_e         walk,
    input  logic [CW-1:0] col_cur,
    input  logic [CW-1:0] col_lo,
    input  logic [CW-1:0] col_hi,
    input  logic [RW-1:0] row_cur,
    input  logic [RW-1:0] row_lo,
    input  logic [RW-1:0] row_hi,
    output logic [CW-1:0] col_nxt,
    output logic [RW-1:0] row_nxt
);

    logic [CW:0] c_tmp;
    logic [RW:0] r_tmp;

    // Compute the next position in one extra bit so overflow is comparable.
    always_comb begin
        c_tmp = {1'b0, col_cur};
        r_tmp = {1'b0, row_cur};
        if (walk == WALK_ROW_FIRST) begin
            r_tmp = r_tmp + 1'b1;
            if (r_tmp > {1'b0, row_hi}) begin
                r_tmp = {1'b0, row_lo};
                c_tmp = c_tmp + 1'b1;
            end
            if (c_tmp > {1'b0, col_hi}) begin
                c_tmp = {1'b0, col_lo};
            end
        end else begin
            c_tmp = c_tmp + 1'b1;
            if (c_tmp > {1'b0, col_hi}) begin
                c_tmp = {1'b0, col_lo};
                r_tmp = r_tmp + 1'b1;
            end
            if (r_tmp > {1'b0, row_hi}) begin
                r_tmp = {1'b0, row_lo};
            end
        end
        col_nxt = c_tmp[CW-1:0];
        row_nxt = r_tmp[RW-1:0];
    end

endmodule

// File: rtl/wfb_dirty_flag.sv
// Change flag for the scan-out side: set by any write, cleared by an
// acknowledge. A set and a clear in the same cycle leave the flag set.
// Assumes: clr is a single-cycle pulse.
module wfb_dirty_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set,
    input  logic clr,
    output logic flag
);

    // Flag register, with set taking priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (set) begin
            flag <= 1'b1;
        end else if (clr) begin
            flag <= 1'b0;
        end
    end

endmodule

// File: rtl/wfb_frame_mem.sv
// Simple dual-port frame store: one synchronous write port and one read port
// with a registered output.
// Assumes: the addresses stay below DEPTH; the contents are not reset.
module wfb_frame_mem #(
    parameter int DEPTH = 5120,
    parameter int DW    = 8,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] store [DEPTH];

    // Write port.
    always_ff @(posedge clk) begin
        if (we) begin
            store[waddr] <= wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        rdata <= store[raddr];
    end

endmodule

// File: rtl/wfb_addr_seq.sv
// Windowed framebuffer address sequencer: writes each pixel byte at the
// current (column, row) pointer, then walks the pointer inside the two axis
// windows in the selected order. It also raises a dirty flag for scan-out and
// holds the frame memory.
// Assumes: window loads are one-cycle pulses; walk_vert is a steady level.
module wfb_addr_seq
    import wfb_pkg::*;
#(
    parameter  int NCOLS = 64,
    parameter  int NROWS = 80,
    parameter  int DW    = 8,
    parameter  int WIN_W = 8,
    localparam int CW    = $clog2(NCOLS),
    localparam int RW    = $clog2(NROWS),
    localparam int DEPTH = NCOLS * NROWS,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             px_valid,
    input  logic [DW-1:0]    px_data,
    input  logic             col_load,
    input  logic [WIN_W-1:0] col_lo_in,
    input  logic [WIN_W-1:0] col_hi_in,
    input  logic             row_load,
    input  logic [WIN_W-1:0] row_lo_in,
    input  logic [WIN_W-1:0] row_hi_in,
    input  logic             walk_vert,
    input  logic             dirty_ack,
    output logic             mem_we,
    output logic [AW-1:0]    mem_addr,
    output logic [DW-1:0]    mem_wdata,
    output logic             dirty,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data
);

    walk_e         walk;
    logic [CW-1:0] col_cur, col_lo, col_hi, col_nxt;
    logic [RW-1:0] row_cur, row_lo, row_hi, row_nxt;

    // Walk order taken from the mode level.
    always_comb walk = walk_e'(walk_vert);

    wfb_axis_window #(.N(NCOLS), .IW(WIN_W)) col_axis_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (col_load),
        .lo_in   (col_lo_in),
        .hi_in   (col_hi_in),
        .step_en (px_valid),
        .nxt     (col_nxt),
        .cur     (col_cur),
        .lo      (col_lo),
        .hi      (col_hi)
    );

    wfb_axis_window #(.N(NROWS), .IW(WIN_W)) row_axis_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (row_load),
        .lo_in   (row_lo_in),
        .hi_in   (row_hi_in),
        .step_en (px_valid),
        .nxt     (row_nxt),
        .cur     (row_cur),
        .lo      (row_lo),
        .hi      (row_hi)
    );

    wfb_walk_step #(.CW(CW), .RW(RW)) step_i (
        .walk    (walk),
        .col_cur (col_cur),
        .col_lo  (col_lo),
        .col_hi  (col_hi),
        .row_cur (row_cur),
        .row_lo  (row_lo),
        .row_hi  (row_hi),
        .col_nxt (col_nxt),
        .row_nxt (row_nxt)
    );

    // Write port: linear address from the pre-edge pointer.
    always_comb begin
        mem_we    = px_valid;
        mem_wdata = px_data;
        mem_addr  = AW'(row_cur) * AW'(NCOLS) + AW'(col_cur);
    end

    wfb_dirty_flag dirty_i (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (px_valid),
        .clr   (dirty_ack),
        .flag  (dirty)
    );

    wfb_frame_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) mem_i (
        .clk   (clk),
        .we    (mem_we),
        .waddr (mem_addr),
        .wdata (mem_wdata),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

endmodule

// File: rtl/wfb_addr_seq_chk.sv
// Property checker for the windowed framebuffer address sequencer, observed
// at the ports of the top module and bound into it below.
// Assumes: reset is synchronous and active low.
module wfb_addr_seq_chk #(
    parameter int NCOLS = 64,
    parameter int NROWS = 80,
    parameter int WIN_W = 8,
    parameter int AW    = 13
) (
    input logic             clk,
    input logic             rst_n,
    input logic             px_valid,
    input logic             col_load,
    input logic [WIN_W-1:0] col_lo_in,
    input logic             row_load,
    input logic [WIN_W-1:0] row_lo_in,
    input logic             dirty_ack,
    input logic             mem_we,
    input logic [AW-1:0]    mem_addr,
    input logic             dirty
);

    // R1: every write lands inside the frame
    a_r1_addr_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (int'(mem_addr) < NCOLS * NROWS));

    // R4: a column load places the pointer on the reduced start
    a_r4_col_load: assert property (@(posedge clk) disable iff (!rst_n)
        col_load |=> ((int'(mem_addr) % NCOLS) == (int'($past(col_lo_in)) % NCOLS)));

    // R4: a row load places the pointer on the reduced start
    a_r4_row_load: assert property (@(posedge clk) disable iff (!rst_n)
        row_load |=> ((int'(mem_addr) / NCOLS) == (int'($past(row_lo_in)) % NROWS)));

    // R7: a write raises the flag
    a_r7_dirty_set: assert property (@(posedge clk) disable iff (!rst_n)
        px_valid |=> dirty);

    // R7: an acknowledge without a write clears the flag
    a_r7_dirty_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty_ack && !px_valid) |=> !dirty);

    // R7: without an acknowledge the flag stays set
    a_r7_dirty_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (dirty && !dirty_ack) |=> dirty);

    // R8: with no write and no load the pointer holds
    a_r8_pointer_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!px_valid && !col_load && !row_load) |=> $stable(mem_addr));

endmodule

bind wfb_addr_seq wfb_addr_seq_chk #(
    .NCOLS (NCOLS),
    .NROWS (NROWS),
    .WIN_W (WIN_W),
    .AW    (AW)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .px_valid  (px_valid),
    .col_load  (col_load),
    .col_lo_in (col_lo_in),
    .row_load  (row_load),
    .row_lo_in (row_lo_in),
    .dirty_ack (dirty_ack),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .dirty     (dirty)
);

// File: tb/wfb_addr_seq_tb.sv
`timescale 1ns/100ps
// Scoreboard bench: the driver pushes expected writes, the monitor pops them.
module wfb_addr_seq_tb_top;

    localparam int NC = 64;
    localparam int NR = 80;
    localparam int AW = 13;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          px_valid = 1'b0;
    logic [7:0]    px_data = '0;
    logic          col_load = 1'b0;
    logic [7:0]    col_lo_in = '0;
    logic [7:0]    col_hi_in = '0;
    logic          row_load = 1'b0;
    logic [7:0]    row_lo_in = '0;
    logic [7:0]    row_hi_in = '0;
    logic          walk_vert = 1'b0;
    logic          dirty_ack = 1'b0;
    logic          mem_we;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_wdata;
    logic          dirty;
    logic [AW-1:0] rd_addr = '0;
    logic [7:0]    rd_data;

    always #2.5 clk = ~clk;

    wfb_addr_seq #(.NCOLS(NC), .NROWS(NR)) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .px_valid  (px_valid),
        .px_data   (px_data),
        .col_load  (col_load),
        .col_lo_in (col_lo_in),
        .col_hi_in (col_hi_in),
        .row_load  (row_load),
        .row_lo_in (row_lo_in),
        .row_hi_in (row_hi_in),
        .walk_vert (walk_vert),
        .dirty_ack (dirty_ack),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .dirty     (dirty),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    typedef struct {
        int    addr;
        int    data;
        string req;
    } exp_t;

    exp_t sb_q[$];
    exp_t got;
    int   checks = 0;
    int   errors = 0;
    bit   vmode  = 1'b0;
    // Pointer and window model, from the requirements.
    int   mc = 0, mr = 0, mcs = 0, mce = NC - 1, mrs = 0, mre = NR - 1;

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // One driven cycle: sets the inputs, pushes the expected write, updates the model.
    task automatic go(input bit v, input int d, input bit lc, input int cs, input int ce,
                      input bit lr, input int rs, input int re, input bit ack, input string req);
        int c, r;
        @(posedge clk);
        #1;
        px_valid  = v;
        px_data   = d[7:0];
        col_load  = lc;
        col_lo_in = cs[7:0];
        col_hi_in = ce[7:0];
        row_load  = lr;
        row_lo_in = rs[7:0];
        row_hi_in = re[7:0];
        dirty_ack = ack;
        walk_vert = vmode;
        c = mc;
        r = mr;
        if (v) begin
            sb_q.push_back('{mr * NC + mc, d & 255, req});
            if (vmode) begin
                r = r + 1;
                if (r > mre) begin r = mrs; c = c + 1; end
                if (c > mce) c = mcs;
            end else begin
                c = c + 1;
                if (c > mce) begin c = mcs; r = r + 1; end
                if (r > mre) r = mrs;
            end
        end
        if (lc) begin mcs = cs % NC; mce = ce % NC; c = mcs; end
        if (lr) begin mrs = rs % NR; mre = re % NR; r = mrs; end
        mc = c;
        mr = r;
    endtask

    task automatic wr(input int d, input string req);
        go(1'b1, d, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, req);
    endtask

    task automatic idle();
        go(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, "");
    endtask

    task automatic win(input int cs, input int ce, input int rs, input int re);
        go(1'b0, 0, 1'b1, cs, ce, 1'b1, rs, re, 1'b0, "");
    endtask

    task automatic rd(input int a, input int exp);
        @(posedge clk);
        #1;
        rd_addr = a[AW-1:0];
        @(posedge clk);
        @(negedge clk);
        check("R9 readback", int'(rd_data), exp);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    // Monitor: compare each write the design produces against the queue.
    always @(negedge clk) begin
        if (rst_n && mem_we) begin
            if (sb_q.size() == 0) begin
                checks++;
                errors++;
                $display("FAIL R1: unexpected write, actual addr %0d expected none", mem_addr);
            end else begin
                got = sb_q.pop_front();
                check(got.req, int'(mem_addr), got.addr);
                check(got.req, int'(mem_wdata), got.data);
            end
        end
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check("R5 reset addr", int'(mem_addr), 0);
        check("R7 reset dirty", int'(dirty), 0);
        check("R1 reset we", int'(mem_we), 0);

        // R5: full-frame linear fill from reset, wrapping 5119 -> 0
        for (int i = 0; i <= NC * NR; i++) wr(i, "R5 full frame");
        idle();
        // R9: read back written bytes
        rd(100, 100);
        rd(NC * NR - 1, (NC * NR - 1) & 255);
        rd(0, (NC * NR) & 255);

        // R7: dirty set, cleared, and write-wins
        @(negedge clk);
        check("R7 dirty after writes", int'(dirty), 1);
        go(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b1, "");
        idle();
        @(negedge clk);
        check("R7 ack clears", int'(dirty), 0);
        go(1'b1, 8'h5A, 1'b0, 0, 0, 1'b0, 0, 0, 1'b1, "R7 write with ack");
        idle();
        @(negedge clk);
        check("R7 write wins over ack", int'(dirty), 1);
        go(1'b0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b1, "");
        idle();
        @(negedge clk);
        check("R7 second clear", int'(dirty), 0);

        // R2: column-first walk in window cols 2..4, rows 10..11
        vmode = 1'b0;
        win(2, 4, 10, 11);
        idle();
        @(negedge clk);
        check("R4 window load pointer", int'(mem_addr), 10 * NC + 2);
        for (int i = 0; i < 8; i++) wr(16 + i, "R2 column-first");
        // R8: idle cycles leave the pointer in place
        repeat (3) idle();
        wr(8'h77, "R8 pointer holds");

        // R3: row-first walk in the same window
        vmode = 1'b1;
        win(2, 4, 10, 11);
        for (int i = 0; i < 8; i++) wr(32 + i, "R3 row-first");

        // R4: modulo reduction, start past end
        vmode = 1'b0;
        win(70, 130, 200, 85);
        idle();
        @(negedge clk);
        check("R4 modulo load", int'(mem_addr), 40 * NC + 6);
        for (int i = 0; i < 3; i++) wr(48 + i, "R4 degenerate window");
        win(191, 255, 159, 239);
        idle();
        @(negedge clk);
        check("R4 modulo top corner", int'(mem_addr), 79 * NC + 63);

        // R6: loads on a write cycle
        win(2, 4, 10, 11);
        wr(1, "R6 before");
        wr(2, "R6 before");
        go(1'b1, 8'hAB, 1'b1, 20, 22, 1'b1, 30, 31, 1'b0, "R6 write uses old pointer");
        for (int i = 0; i < 4; i++) wr(60 + i, "R6 after dual load");
        go(1'b1, 8'hCD, 1'b1, 5, 6, 1'b0, 0, 0, 1'b0, "R6 column-only load");
        for (int i = 0; i < 3; i++) wr(70 + i, "R6 after column load");
        vmode = 1'b1;
        go(1'b1, 8'hEF, 1'b0, 0, 0, 1'b1, 3, 4, 1'b0, "R6 row-only load");
        for (int i = 0; i < 3; i++) wr(80 + i, "R6 after row load");
        idle();
        idle();
        check("R1 queue drained", sb_q.size(), 0);

        summary();
        $finish;
    end

endmodule